// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM of 128K words of 24 bits. The host raises a request together with a write flag, a word address and write data, and holds them until the block answers with a single-cycle done pulse. For a read, the answering cycle also presents the captured word on the read-data output. Because the memory has no clock, the block produces its chip-select, write-enable and output-enable strobes (all active low), the address, and a split data bus (outgoing data, incoming data and per-lane drive enables) from registers. It counts cycles so that access time, write pulse width and bus hand-over are met.

The memory word consists of byte-wide lanes that share the address and strobes, so every write stores all lanes together. The read access count and the write pulse count are parameters in clock cycles. They are picked to suit the memory speed grade and the system clock. The block holds output enable high for every write, so the plain minimum write pulse applies and the longer pulse needed when outputs are enabled is never required. One idle cycle follows each read that is directly followed by a write, so the memory has released the bus before the block drives it.

Top module: `asram_seq`

## Requirements
- R1: After reset, chip select, write enable and output enable are high (1), every data-lane drive enable is 0 and done is 0.
- R2: A read request accepted at a clock edge drives chip select and output enable low, with write enable high, from that edge for exactly RD_CYC cycles, after which both return high.
- R3: At the edge that ends the read window, the word on the incoming data bus is registered onto the read-data output and stays there until the next read completes.
- R4: A write request accepted at a clock edge drives chip select and write enable low for exactly WP_CYC cycles while output enable stays high, and the outgoing bus carries the full 24-bit write data on all lanes together.
- R5: The drive enables (1 = block drives the lane) are 1 exactly while write enable is low, drop in the same cycle write enable rises, and are never 1 while output enable is low.
- R6: The memory address equals the address accepted with the request and stays constant for as long as chip select is low.
- R7: Done is 1 for exactly one cycle per operation, in the cycle right after the strobes return high; the next request can be accepted at the following edge.
- R8: If a write is requested in the first idle cycle after a read, it is held one extra cycle, so output enable has been high for at least two cycles before write enable falls; a read after a read, or any operation after a write, gets no extra cycle.
- R9: Changes to the request inputs (write flag, address, write data) while an operation is in progress have no effect on the memory pins of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request, held until done |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 24 | Word to write |
| rdata_o | output | 24 | Last word read |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 17 | Memory address |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 24 | Data driven toward the memory |
| mem_dq_i | input | 24 | Data returned by the memory |
| mem_dq_oe_o | output | 3 | Per-lane drive enable, 1 = drive |

## Verification
The bench builds the block with a read window of four cycles and a write pulse of two cycles, so the two counts differ and a swapped or shortened count moves an edge that the bench checks. Its memory model returns a garbage pattern until output enable has been low for all but the last cycle of the read window, so capturing even one edge early yields a wrong word. Back-to-back sequences of read then write, write then read, read then read, idle gaps and address extremes reach the turnaround rule and its exceptions. Input scrambling mid-operation exercises the hold behaviour.

// File: rtl/asram_pkg.sv
package asram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } asram_state_e;
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // a decrement is only requested while the window is still open (R2, R4)
    assert_no_dec_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/asram_lane.sv
module asram_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_w,
    input  logic [W-1:0] wdata,
    input  logic         drive_on,
    input  logic         drive_off,
    input  logic         cap,
    input  logic [W-1:0] dq_in,
    output logic [W-1:0] dq_out,
    output logic         dq_oe,
    output logic [W-1:0] rd_out
);
    typedef struct packed {
        logic [W-1:0] wr;
        logic         oe;
        logic [W-1:0] rd;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (load_w)    ln_d.wr = wdata;
        if (drive_on)  ln_d.oe = 1'b1;
        if (drive_off) ln_d.oe = 1'b0;
        if (cap)       ln_d.rd = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign dq_out = ln_q.wr;
    assign dq_oe  = ln_q.oe;
    assign rd_out = ln_q.rd;

    // on and off are never requested together (R5)
    assert_drive_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_on && drive_off));
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 24,
    parameter int LANE_W = 8,
    parameter int RD_CYC = 3,
    parameter int WP_CYC = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_i,
    input  logic                       wr_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic                       done_o,
    output logic [ADDR_W-1:0]          mem_addr_o,
    output logic                       mem_cs_n_o,
    output logic                       mem_we_n_o,
    output logic                       mem_oe_n_o,
    output logic [DATA_W-1:0]          mem_dq_o,
    input  logic [DATA_W-1:0]          mem_dq_i,
    output logic [DATA_W/LANE_W-1:0]   mem_dq_oe_o
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int MAXC  = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

    typedef struct packed {
        asram_state_e       st;
        logic               cs_n;
        logic               we_n;
        logic               oe_n;
        logic               done;
        logic               turn;
        logic [ADDR_W-1:0]  addr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                 done: 1'b0, turn: 1'b0, addr: '0};

    ctl_t ctl_d, ctl_q;

    logic             t_load, t_dec, t_zero;
    logic [CNT_W-1:0] t_val;
    logic             ld_w, drv_on, drv_off, cap;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        t_dec    = 1'b0;
        ld_w     = 1'b0;
        drv_on   = 1'b0;
        drv_off  = 1'b0;
        cap      = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.turn = 1'b0;
                if (req_i && !(wr_i && ctl_q.turn)) begin
                    ctl_d.cs_n = 1'b0;
                    ctl_d.addr = addr_i;
                    t_load     = 1'b1;
                    if (wr_i) begin
                        ctl_d.st   = ST_WRITE;
                        ctl_d.we_n = 1'b0;
                        ld_w       = 1'b1;
                        drv_on     = 1'b1;
                        t_val      = WP_LOAD;
                    end else begin
                        ctl_d.st   = ST_READ;
                        ctl_d.oe_n = 1'b0;
                        t_val      = RD_LOAD;
                    end
                end
            end
            ST_READ: begin
                if (t_zero) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.done = 1'b1;
                    ctl_d.turn = 1'b1;
                    cap        = 1'b1;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_WRITE: begin
                if (t_zero) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.we_n = 1'b1;
                    ctl_d.done = 1'b1;
                    drv_off    = 1'b1;
                end else begin
                    t_dec = 1'b1;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .zero     (t_zero)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        asram_lane #(.W(LANE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_w    (ld_w),
            .wdata     (wdata_i[g*LANE_W +: LANE_W]),
            .drive_on  (drv_on),
            .drive_off (drv_off),
            .cap       (cap),
            .dq_in     (mem_dq_i[g*LANE_W +: LANE_W]),
            .dq_out    (mem_dq_o[g*LANE_W +: LANE_W]),
            .dq_oe     (mem_dq_oe_o[g]),
            .rd_out    (rdata_o[g*LANE_W +: LANE_W])
        );
    end

    assign done_o     = ctl_q.done;
    assign mem_addr_o = ctl_q.addr;
    assign mem_cs_n_o = ctl_q.cs_n;
    assign mem_we_n_o = ctl_q.we_n;
    assign mem_oe_n_o = ctl_q.oe_n;

    // strobe-length counters used only by the checks below
    logic [CNT_W:0] we_low_q, oe_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q <= '0;
            oe_low_q <= '0;
        end else begin
            we_low_q <= mem_we_n_o ? '0 : we_low_q + 1'b1;
            oe_low_q <= mem_oe_n_o ? '0 : oe_low_q + 1'b1;
        end
    end

    assert_rd_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n_o) |-> (oe_low_q == (CNT_W+1)'(RD_CYC)));
    assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (we_low_q == (CNT_W+1)'(WP_CYC)));
    assert_oe_high_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_oe_n_o);
    assert_lanes_together_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe_o == '0) || (&mem_dq_oe_o));
    assert_drive_needs_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_dq_oe_o) |-> (!mem_we_n_o && !mem_cs_n_o));
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mem_cs_n_o && mem_we_n_o && mem_oe_n_o));
    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> $past(mem_oe_n_o, 2));
endmodule

// File: tb/asram_seq_test.sv
`timescale 1ns/1ps
module asram_seq_test;
    localparam int AW = 17;
    localparam int DW = 24;
    localparam int LW = 8;
    localparam int NL = DW / LW;
    localparam int RD = 4;
    localparam int WP = 2;
    localparam logic [DW-1:0] JUNK = 24'hA5C35A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_i = 1'b0, wr_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic done_o;
    logic [AW-1:0] mem_addr_o;
    logic mem_cs_n_o, mem_we_n_o, mem_oe_n_o;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = JUNK;
    logic [NL-1:0] mem_dq_oe_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    asram_seq #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .RD_CYC(RD), .WP_CYC(WP)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .mem_addr_o(mem_addr_o),
        .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
        .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe_o(mem_dq_oe_o));

    function automatic logic [DW-1:0] init_word(logic [AW-1:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8], 7'h11, a[16]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // ---------------- memory device model ----------------
    logic [DW-1:0] dev_mem [int];
    int lowc = 0;
    always @(posedge clk) lowc <= (!mem_cs_n_o && !mem_oe_n_o) ? lowc + 1 : 0;
    always @(negedge clk) begin
        if (!mem_cs_n_o && !mem_we_n_o && (&mem_dq_oe_o))
            dev_mem[int'(mem_addr_o)] = mem_dq_o;
        if (!mem_cs_n_o && !mem_oe_n_o && mem_we_n_o && lowc >= RD - 1)
            mem_dq_i = dev_mem.exists(int'(mem_addr_o)) ? dev_mem[int'(mem_addr_o)] : init_word(mem_addr_o);
        else
            mem_dq_i = JUNK;
        if (rst_n && (|mem_dq_oe_o) && !mem_oe_n_o)
            chk(1'b0, "R5 bus conflict", 32'(mem_dq_oe_o), 32'h0);
    end

    // ---------------- cycle reference model ----------------
    logic [DW-1:0] ref_mem [int];
    int left = 0;
    bit rd_end = 1'b0, e_turn = 1'b0;
    bit e_cs = 1'b1, e_we = 1'b1, e_oe = 1'b1, e_drv = 1'b0, e_done = 1'b0;
    bit m_wr = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0, e_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            left = 0; rd_end = 0; e_turn = 0;
            e_cs = 1; e_we = 1; e_oe = 1; e_drv = 0; e_done = 0;
        end else begin
            e_done = 0;
            e_turn = 0;
            if (left > 0) begin
                left--;
                if (left == 0) begin
                    e_cs = 1; e_we = 1; e_oe = 1; e_drv = 0; e_done = 1;
                    if (m_wr) ref_mem[int'(m_addr)] = m_data;
                    else begin
                        e_rdata = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : init_word(m_addr);
                        rd_end = 1;
                    end
                end
            end else begin
                if (req_i && wr_i && rd_end) e_turn = 1;
                else if (req_i) begin
                    m_wr = wr_i; m_addr = addr_i; m_data = wdata_i; e_cs = 0;
                    if (wr_i) begin e_we = 0; e_drv = 1; left = WP; end
                    else begin e_oe = 0; left = RD; end
                end
                rd_end = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(mem_cs_n_o == e_cs, e_turn ? "R8 held cycle" : "R2 chip select", 32'(mem_cs_n_o), 32'(e_cs));
            chk(mem_oe_n_o == e_oe, (m_wr && !e_cs) ? "R4 oe high in write" : "R2 output enable", 32'(mem_oe_n_o), 32'(e_oe));
            chk(mem_we_n_o == e_we, "R4 write enable", 32'(mem_we_n_o), 32'(e_we));
            chk(mem_dq_oe_o == {NL{e_drv}}, "R5 drive enables", 32'(mem_dq_oe_o), 32'({NL{e_drv}}));
            chk(done_o == e_done, "R7 done", 32'(done_o), 32'(e_done));
            if (!e_cs) chk(mem_addr_o == m_addr, "R6 R9 address", 32'(mem_addr_o), 32'(m_addr));
            if (e_drv) chk(mem_dq_o == m_data, "R4 R9 write data", 32'(mem_dq_o), 32'(m_data));
            if (e_done && !m_wr) chk(rdata_o == e_rdata, "R3 read data", 32'(rdata_o), 32'(e_rdata));
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d;
        @(negedge clk);
        while (mem_cs_n_o) @(negedge clk);
        wr_i = ~w; addr_i = ~a; wdata_i = ~d;   // R9: scramble mid-operation
        while (!done_o) @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] lcg;
        lcg = 32'h1234_5678;
        repeat (4) begin
            @(negedge clk);
            chk(mem_cs_n_o && mem_we_n_o && mem_oe_n_o, "R1 strobes in reset",
                32'({mem_cs_n_o, mem_we_n_o, mem_oe_n_o}), 32'h7);
            chk(mem_dq_oe_o == '0 && !done_o, "R1 drivers and done in reset",
                32'({mem_dq_oe_o, done_o}), 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b1, 17'h00000, 24'hFFFFFF);
        issue(1'b0, 17'h00000, 24'h0);          // write then read
        issue(1'b0, 17'h1FFFF, 24'h0);          // read then read, unwritten word
        issue(1'b1, 17'h1FFFF, 24'h000000);     // read then write: held one cycle
        issue(1'b1, 17'h0AAAA, 24'h123456);     // write then write
        issue(1'b0, 17'h0AAAA, 24'h0);
        issue(1'b0, 17'h1FFFF, 24'h0);
        idle(3);
        issue(1'b0, 17'h00000, 24'h0);
        idle(1);
        issue(1'b1, 17'h00005, 24'hABCDEF);     // read, gap, write: no extra cycle
        issue(1'b0, 17'h00005, 24'h0);
        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            issue(lcg[31], {lcg[20:17], lcg[12:0]} & 17'h0003F, lcg[23:0] ^ 24'h0F0F0F);
            if (lcg[5:4] == 2'b00) idle(int'(lcg[7:6]) + 1);
        end
        idle(4);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule